// File: doc/BRIEF.md
# Event Performance Counter Unit

This block holds a small bank of 32-bit event counters for a processor core. Each counter has its own control word. The control word picks one of 64 event lines, the privilege modes in which counting is allowed, an optional filter on the current virtual processor or hardware thread, and an interrupt enable. Each clock in which the selected event is high and all filters pass adds one to the counter.

A counter asks for service once its most significant bit is set and its interrupt enable is on. Software arms a sample by loading the counter with 0x80000000 minus the wanted period. It then takes the level interrupt, checks the shared pending flag, and reloads each counter that has fired. The top bit of each control word reports whether another counter follows. Walking that chain tells software how many counters the instance has.

Top module: `evctr_unit`

## Requirements
- R1: After reset every counter and every stored control field is zero, and irq_o and irq_pend_o are low. A control read returns only the chain bit.
- R2: A counter adds exactly one per clock edge while its selected event line is high and its mode and thread filters pass.
- R3: Control bits 0 to 3 enable counting at exception level, in kernel, supervisor and user mode, and line up with priv_lvl bits 0 to 3. A counter counts only when at least one active priv_lvl bit is also enabled.
- R4: Control bits [10:5] select which line of evt_vec the counter watches. No other line has any effect on the counter.
- R5: Control bits [21:20] choose the thread filter. Value 0 counts for every thread. Value 1 counts only while vpe_id equals bits [19:16]. Value 2 counts only while tc_id equals bits [29:22]. Value 3 never counts.
- R6: A control read returns bit 31 = 1 when a higher-numbered counter exists and 0 for the last counter. Bit 30 and bits [15:11] always read 0.
- R7: A counter requests service while its bit 31 is set and control bit 4 is 1. irq_o and irq_pend_o both equal the OR of all requests.
- R8: The request stays active until the counter is rewritten with bit 31 clear or its enable is cleared. After that, irq_o falls on the same edge.
- R9: When software writes a counter on the same edge as a counting event, the written value is stored and the increment is lost.
- R10: A counter at 0xFFFFFFFF that counts goes to 0, with no other effect.
- R11: Writing zero to a control register stops its counter, and the counter keeps its value.
- R12: Register indices at or above NUM_CTR read as 0. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 2 | Counter number for the register access |
| reg_ctl | input | 1 | 1 selects the control word, 0 selects the counter value |
| reg_we | input | 1 | Write strobe, taken at the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected register (combinational) |
| evt_vec | input | EVT_N | Event lines from the core |
| priv_lvl | input | 4 | Active modes: bit0 exception, bit1 kernel, bit2 supervisor, bit3 user |
| vpe_id | input | 4 | Current virtual processor number |
| tc_id | input | 8 | Current hardware thread number |
| irq_o | output | 1 | Level interrupt request |
| irq_pend_o | output | 1 | Shared pending flag |

## Verification
Two things can land on the same edge: a software write to a counter and a counting event for that same counter. The bench holds the event line high and issues the counter write during the counting run. A correct design stores exactly the written value, with no extra one added. A second coincidence is the event that carries a counter across 0x80000000 and changes the interrupt level. The bench steps the counter through that boundary, and then through the reload that clears the request. It samples irq_o and irq_pend_o after each edge.

// File: rtl/evctr_pkg.sv
package evctr_pkg;
   localparam int REG_W   = 32;
   localparam int VPE_W   = 4;
   localparam int TC_W    = 8;
   localparam int IDX_W   = 2;
   localparam int MAX_CTR = 4;

   // control word field positions (decoded by software)
   localparam int P_IE     = 4;
   localparam int P_EVT_LO = 5;
   localparam int EVT_FW   = 6;
   localparam int P_VPE_LO = 16;
   localparam int P_TF_LO  = 20;
   localparam int P_TC_LO  = 22;
   localparam int P_MORE   = 31;

   // writable bits: modes, IE, event, VPE, filter, TC
   localparam logic [REG_W-1:0] CTL_WMASK = 32'h3FFF_07FF;

   typedef enum logic [1:0] {
      TF_ANY  = 2'd0,
      TF_VPE  = 2'd1,
      TF_TC   = 2'd2,
      TF_NONE = 2'd3
   } thr_filt_e;
endpackage

// File: rtl/evctr_filter.sv
module evctr_filter
   import evctr_pkg::*;
#(
   parameter int EVT_N = 64
) (
   input  logic [REG_W-1:0] ctl,
   input  logic [EVT_N-1:0] evt,
   input  logic [3:0]       priv,
   input  logic [VPE_W-1:0] vpe,
   input  logic [TC_W-1:0]  tc,
   output logic             hit
);
   localparam int SEL_W = $clog2(EVT_N);

   logic [SEL_W-1:0] sel;
   logic             mode_ok;
   logic             thr_ok;
   thr_filt_e        tf;

   assign sel     = ctl[P_EVT_LO +: SEL_W];
   assign mode_ok = |(ctl[3:0] & priv);
   assign tf      = thr_filt_e'(ctl[P_TF_LO +: 2]);

   always_comb begin
      unique case (tf)
         TF_ANY:  thr_ok = 1'b1;
         TF_VPE:  thr_ok = (ctl[P_VPE_LO +: VPE_W] == vpe);
         TF_TC:   thr_ok = (ctl[P_TC_LO +: TC_W] == tc);
         default: thr_ok = 1'b0;
      endcase
   end

   assign hit = evt[sel] & mode_ok & thr_ok;
endmodule

// File: rtl/evctr_slot.sv
module evctr_slot
   import evctr_pkg::*;
#(
   parameter int IDX   = 0,
   parameter int NUM   = 4,
   parameter int EVT_N = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             cnt_we,
   input  logic [REG_W-1:0] wdata,
   input  logic [EVT_N-1:0] evt,
   input  logic [3:0]       priv,
   input  logic [VPE_W-1:0] vpe,
   input  logic [TC_W-1:0]  tc,
   output logic [REG_W-1:0] ctl_rd,
   output logic [REG_W-1:0] cnt_q,
   output logic [3:0]       mode_en,
   output logic             req
);
   logic [REG_W-1:0] ctl_q;
   logic             hit;
   logic             more;

   generate
      if (IDX < NUM - 1) begin : g_chain
         assign more = 1'b1;
      end else begin : g_last
         assign more = 1'b0;
      end
   endgenerate

   evctr_filter #(.EVT_N(EVT_N)) i_filter (
      .ctl  (ctl_q),
      .evt  (evt),
      .priv (priv),
      .vpe  (vpe),
      .tc   (tc),
      .hit  (hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (ctl_we) begin
         ctl_q <= wdata & CTL_WMASK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_we) begin
         cnt_q <= wdata;
      end else if (hit) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_comb begin
      ctl_rd         = ctl_q;
      ctl_rd[P_MORE] = more;
   end

   assign mode_en = ctl_q[3:0];
   assign req     = cnt_q[REG_W-1] & ctl_q[P_IE];
endmodule

// File: rtl/evctr_unit.sv
module evctr_unit
   import evctr_pkg::*;
#(
   parameter int NUM_CTR = 3,
   parameter int EVT_N   = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_idx,
   input  logic             reg_ctl,
   input  logic             reg_we,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic [EVT_N-1:0] evt_vec,
   input  logic [3:0]       priv_lvl,
   input  logic [3:0]       vpe_id,
   input  logic [7:0]       tc_id,
   output logic             irq_o,
   output logic             irq_pend_o
);
   generate
      if (NUM_CTR < 1 || NUM_CTR > MAX_CTR) begin : g_bad_num
         $error("evctr_unit: NUM_CTR must lie in 1..4");
      end
      if (EVT_N < 2 || EVT_N > (1 << EVT_FW) || (EVT_N & (EVT_N - 1)) != 0) begin : g_bad_evt
         $error("evctr_unit: EVT_N must be a power of two up to 64");
      end
   endgenerate

   logic [NUM_CTR-1:0]            ctl_we;
   logic [NUM_CTR-1:0]            cnt_we;
   logic [NUM_CTR-1:0]            req;
   logic [NUM_CTR-1:0][REG_W-1:0] ctl_rd;
   logic [NUM_CTR-1:0][REG_W-1:0] cnt_all;
   logic [NUM_CTR-1:0][3:0]       mode_en;

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
         assign ctl_we[i] = reg_we &  reg_ctl & (reg_idx == IDX_W'(i));
         assign cnt_we[i] = reg_we & ~reg_ctl & (reg_idx == IDX_W'(i));

         evctr_slot #(.IDX(i), .NUM(NUM_CTR), .EVT_N(EVT_N)) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (ctl_we[i]),
            .cnt_we  (cnt_we[i]),
            .wdata   (reg_wdata),
            .evt     (evt_vec),
            .priv    (priv_lvl),
            .vpe     (vpe_id),
            .tc      (tc_id),
            .ctl_rd  (ctl_rd[i]),
            .cnt_q   (cnt_all[i]),
            .mode_en (mode_en[i]),
            .req     (req[i])
         );
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (reg_idx == IDX_W'(i)) begin
            reg_rdata = reg_ctl ? ctl_rd[i] : cnt_all[i];
         end
      end
   end

   assign irq_pend_o = |req;
   assign irq_o      = |req;
endmodule

// File: rtl/evctr_chk.sv
module evctr_chk #(
   parameter int NUM_CTR = 3
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [1:0]               reg_idx,
   input logic                     reg_ctl,
   input logic [31:0]              reg_rdata,
   input logic                     wr_msb,
   input logic [NUM_CTR-1:0]       cnt_we,
   input logic [NUM_CTR-1:0][31:0] cnt_all,
   input logic [NUM_CTR-1:0][3:0]  mode_en,
   input logic                     irq_o,
   input logic                     irq_pend_o
);
   logic any_msb;

   always_comb begin
      any_msb = 1'b0;
      for (int i = 0; i < NUM_CTR; i++) any_msb |= cnt_all[i][31];
   end

   generate
      for (genvar i = 0; i < NUM_CTR; i++) begin : g_c
         // R2 R10
         step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !cnt_we[i] |=> (cnt_all[i] == $past(cnt_all[i]) ||
                            cnt_all[i] == $past(cnt_all[i]) + 32'd1));
         // R11
         halted_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cnt_we[i] && mode_en[i] == 4'd0) |=> $stable(cnt_all[i]));
         // R8
         reload_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_we[i] && !wr_msb) |=> !cnt_all[i][31]);
      end
   endgenerate

   // R7
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> any_msb);
   // R7
   pend_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == irq_pend_o);
   // R6
   last_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_ctl && reg_idx == 2'(NUM_CTR - 1)) |-> !reg_rdata[31]);
   // R6
   wide_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ctl |-> !reg_rdata[30]);
   // R12
   absent_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(reg_idx) >= NUM_CTR) |-> reg_rdata == 32'd0);
endmodule

bind evctr_unit evctr_chk #(.NUM_CTR(NUM_CTR)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_idx    (reg_idx),
   .reg_ctl    (reg_ctl),
   .reg_rdata  (reg_rdata),
   .wr_msb     (reg_wdata[31]),
   .cnt_we     (cnt_we),
   .cnt_all    (cnt_all),
   .mode_en    (mode_en),
   .irq_o      (irq_o),
   .irq_pend_o (irq_pend_o)
);

// File: tb/test_evctr_unit.sv
module test_evctr_unit;
   localparam int NUM_CTR = 3;
   localparam int EVT_N   = 64;
   localparam int NPULSE  = 5;

   typedef struct packed {
      logic [31:0] ctl;
      logic [3:0]  priv;
      logic [3:0]  vpe;
      logic [7:0]  tc;
      logic [5:0]  ev;
      logic        hit;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t VECS [NV] = '{
      '{32'h0000_00E8, 4'h8, 4'h0, 8'h00, 6'd7,  1'b1},
      '{32'h0000_00E8, 4'h2, 4'h0, 8'h00, 6'd7,  1'b0},
      '{32'h0000_00E3, 4'h1, 4'h0, 8'h00, 6'd7,  1'b1},
      '{32'h0000_00E4, 4'h4, 4'h0, 8'h00, 6'd7,  1'b1},
      '{32'h0015_00E8, 4'h8, 4'h5, 8'h00, 6'd7,  1'b1},
      '{32'h0015_00E8, 4'h8, 4'h4, 8'h00, 6'd7,  1'b0},
      '{32'h26A0_00E8, 4'h8, 4'h0, 8'h9A, 6'd7,  1'b1},
      '{32'h26A0_00E8, 4'h8, 4'h0, 8'h9B, 6'd7,  1'b0},
      '{32'h0030_00E8, 4'h8, 4'h0, 8'h00, 6'd7,  1'b0},
      '{32'h0000_00E8, 4'h8, 4'h0, 8'h00, 6'd8,  1'b0},
      '{32'h0000_07E8, 4'h8, 4'h0, 8'h00, 6'd63, 1'b1}
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [1:0]       reg_idx = '0;
   logic             reg_ctl = 1'b0;
   logic             reg_we = 1'b0;
   logic [31:0]      reg_wdata = '0;
   logic [31:0]      reg_rdata;
   logic [EVT_N-1:0] evt_vec = '0;
   logic [3:0]       priv_lvl = '0;
   logic [3:0]       vpe_id = '0;
   logic [7:0]       tc_id = '0;
   logic             irq_o;
   logic             irq_pend_o;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;

   evctr_unit #(.NUM_CTR(NUM_CTR), .EVT_N(EVT_N)) i_evctr_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_idx    (reg_idx),
      .reg_ctl    (reg_ctl),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .evt_vec    (evt_vec),
      .priv_lvl   (priv_lvl),
      .vpe_id     (vpe_id),
      .tc_id      (tc_id),
      .irq_o      (irq_o),
      .irq_pend_o (irq_pend_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] idx, input logic ctl, input logic [31:0] d);
      @(negedge clk);
      reg_idx = idx; reg_ctl = ctl; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, input logic ctl, output logic [31:0] v);
      reg_idx = idx; reg_ctl = ctl; reg_we = 1'b0;
      #1;
      v = reg_rdata;
   endtask

   task automatic pulse(input int ev, input int n);
      @(negedge clk);
      evt_vec = '0;
      evt_vec[ev] = 1'b1;
      repeat (n) @(negedge clk);
      evt_vec = '0;
   endtask

   task automatic irq_check(input string req, input logic exp);
      check(req, {31'd0, irq_o}, {31'd0, exp});
      check(req, {31'd0, irq_pend_o}, {31'd0, exp});
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < NUM_CTR; i++) begin
         rd(2'(i), 1'b0, v);
         check("R1 counter", v, 32'd0);
         rd(2'(i), 1'b1, v);
         check("R1 control", v, (i < NUM_CTR - 1) ? 32'h8000_0000 : 32'd0);
      end
      irq_check("R1 irq", 1'b0);

      // R12 absent index
      wr(2'd3, 1'b1, 32'hFFFF_FFFF);
      wr(2'd3, 1'b0, 32'h0000_0055);
      rd(2'd3, 1'b1, v); check("R12 read control", v, 32'd0);
      rd(2'd3, 1'b0, v); check("R12 read counter", v, 32'd0);
      for (int i = 0; i < NUM_CTR; i++) begin
         rd(2'(i), 1'b0, v); check("R12 others untouched", v, 32'd0);
      end
      irq_check("R12 irq", 1'b0);

      // R6 read-only and reserved bits
      wr(2'd1, 1'b1, 32'hFFFF_FFFF);
      rd(2'd1, 1'b1, v); check("R6 middle control", v, 32'hBFFF_07FF);
      wr(2'd2, 1'b1, 32'hFFFF_FFFF);
      rd(2'd2, 1'b1, v); check("R6 last control", v, 32'h3FFF_07FF);
      wr(2'd1, 1'b1, 32'd0);
      wr(2'd2, 1'b1, 32'd0);

      // R2 R3 R4 R5 filter table on counter 0
      for (int k = 0; k < NV; k++) begin
         wr(2'd0, 1'b0, 32'd0);
         wr(2'd0, 1'b1, VECS[k].ctl);
         priv_lvl = VECS[k].priv; vpe_id = VECS[k].vpe; tc_id = VECS[k].tc;
         pulse(int'(VECS[k].ev), NPULSE);
         rd(2'd0, 1'b0, v);
         check($sformatf("filter vector %0d (R2 R3 R4 R5)", k), v,
               VECS[k].hit ? 32'(NPULSE) : 32'd0);
         wr(2'd0, 1'b1, 32'd0);
         priv_lvl = '0; vpe_id = '0; tc_id = '0;
      end

      // R9 write coincides with an increment
      priv_lvl = 4'h8;
      wr(2'd0, 1'b0, 32'd0);
      wr(2'd0, 1'b1, 32'h0000_00E8);
      @(negedge clk);
      evt_vec = '0; evt_vec[7] = 1'b1;
      @(negedge clk);
      reg_idx = 2'd0; reg_ctl = 1'b0; reg_wdata = 32'h0000_1234; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; evt_vec = '0;
      rd(2'd0, 1'b0, v); check("R9 write wins", v, 32'h0000_1234);

      // R11 stop keeps value
      wr(2'd0, 1'b0, 32'd0);
      pulse(7, 3);
      rd(2'd0, 1'b0, v); check("R11 before stop", v, 32'd3);
      wr(2'd0, 1'b1, 32'd0);
      pulse(7, 3);
      rd(2'd0, 1'b0, v); check("R11 held after stop", v, 32'd3);

      // R7 R8 overflow request on counter 1
      wr(2'd1, 1'b0, 32'h7FFF_FFFE);
      wr(2'd1, 1'b1, 32'h0000_0078);
      pulse(3, 1);
      rd(2'd1, 1'b0, v); check("R7 below threshold", v, 32'h7FFF_FFFF);
      irq_check("R7 no request yet", 1'b0);
      pulse(3, 1);
      rd(2'd1, 1'b0, v); check("R7 crossing", v, 32'h8000_0000);
      irq_check("R7 request", 1'b1);
      @(negedge clk);
      irq_check("R8 level held", 1'b1);
      wr(2'd1, 1'b1, 32'h0000_0068);
      irq_check("R7 enable off", 1'b0);
      wr(2'd1, 1'b1, 32'h0000_0078);
      irq_check("R7 enable back on", 1'b1);
      wr(2'd1, 1'b0, 32'h0000_0010);
      irq_check("R8 cleared by reload", 1'b0);
      wr(2'd1, 1'b1, 32'd0);

      // R10 wrap on counter 2
      wr(2'd2, 1'b0, 32'hFFFF_FFFF);
      wr(2'd2, 1'b1, 32'h0000_0078);
      irq_check("R10 request at max", 1'b1);
      pulse(3, 1);
      rd(2'd2, 1'b0, v); check("R10 wrap", v, 32'd0);
      irq_check("R10 after wrap", 1'b0);
      wr(2'd2, 1'b1, 32'd0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule